// File: doc/BRIEF.md
# Reset Timeout and Brown-out Controller

This block produces the chip-wide internal reset from three requests: a power-on indication, an external reset request and the digital output of a supply comparator. Internal reset rises in the same cycle that any request is active. It stays high after the last request has gone away until a two-stage timeout has run. The first stage counts ticks of a slow timer; `tick_i` carries one single-cycle pulse per microsecond. The second stage counts a fixed number of system clocks. A two-bit code selects the length of the first stage and whether the second stage is short (18 clocks) or long (1024 clocks).

The comparator output only counts as a brown-out when detection is enabled and the low indication has lasted longer than a minimum number of ticks. The level bit selects that minimum. Once a brown-out is accepted it holds reset until the supply returns. The release then goes through the same timeout as power-on. Three sticky flags record which sources have caused a reset. Software clears them by writing ones.

The default tick counts (32, 4000, 64000 and 64000) suit the higher supply. A build for the lower supply sets the four delay parameters to four times those values.

Top module: `rstseq_ctrl`

## Requirements
- R1: The first timeout stage counts only cycles with `tick_i` high. The number of ticks depends on `dly_sel_i`: 00 gives DLY0_TICKS, 01 gives DLY1_TICKS, 10 gives DLY2_TICKS and 11 gives DLY3_TICKS.
- R2: After the tick stage the block counts 18 system clocks for codes 00, 01 and 10, and 1024 for code 11. With `tick_i` held high, `sys_rst_o` falls after the T+C-th rising edge that counts from the first edge at which no source is active. T is the tick count and C is the clock count.
- R3: While `por_i` is high, `sys_rst_o` is high and the cause flags are forced to 3'b001. The timeout starts at the first edge with `por_i` low.
- R4: `ext_rst_i` raises `sys_rst_o` in the same cycle, with no clock edge needed. Raising it again while the timeout is running restarts the full timeout.
- R5: An accepted brown-out raises `sys_rst_o` directly after the accepting clock edge.
- R6: A low indication on `bod_low_i` is accepted only when it has been seen on more consecutive ticks than the minimum. With `bod_level_i`=1 it needs 4 ticks (minimum 3). With `bod_level_i`=0 it needs 8 ticks (minimum 7). A shorter indication changes neither `sys_rst_o` nor cause bit 2.
- R7: With `bod_en_i` low, `bod_low_i` has no effect. Dropping `bod_en_i` during an accepted brown-out ends that brown-out, and the timeout then runs.
- R8: When `bod_low_i` returns low after an accepted brown-out, `sys_rst_o` falls after T+C+1 rising edges, counted from the first edge at which `bod_low_i` is low.
- R9: `cause_o` bit 0 records power-on, bit 1 records an external reset and bit 2 records a brown-out. The flags are sticky. A one in `flag_clr_i` clears the matching flag, but a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high; also the block's synchronous reset |
| ext_rst_i | input | 1 | External reset request, active high |
| bod_low_i | input | 1 | Supply comparator output, high when the supply is below the trigger |
| bod_en_i | input | 1 | Brown-out detection enable |
| bod_level_i | input | 1 | Trigger level select: 1 = high level (short filter), 0 = low level (long filter) |
| dly_sel_i | input | 2 | Timeout code |
| tick_i | input | 1 | Slow timer enable, one pulse per microsecond |
| flag_clr_i | input | 3 | Write-one-to-clear strobes for the cause flags |
| sys_rst_o | output | 1 | Internal reset, active high |
| cause_o | output | 3 | Sticky reset cause flags {brown-out, external, power-on} |

## Verification
The hardest cases to reach are the boundaries of the brown-out filter. The bench holds the comparator low for exactly the minimum number of ticks and then for one tick more, at both level settings. This shows that the shorter indication leaves no trace and that the longer one raises reset right after the accepting edge. A second case that is hard to reach from the ports is a restart in the middle of the clock stage. The bench releases the external request, waits past the tick stage and pulses the request again. It then expects the full timeout to run once more. To show that only ticks advance the first stage, the bench holds `tick_i` low for many cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int unsigned SHORT_CLKS = 18;
    localparam int unsigned LONG_CLKS  = 1024;
    localparam int unsigned CAUSE_W    = 3;

    typedef enum logic [1:0] {
        DLY_SHORTEST = 2'b00,
        DLY_SHORT    = 2'b01,
        DLY_LONG     = 2'b10,
        DLY_LONGEST  = 2'b11
    } dly_code_e;

    typedef enum logic [1:0] {
        PH_TICKS = 2'd0,
        PH_CLKS  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    // Bit 2 brown-out, bit 1 external, bit 0 power-on
    typedef struct packed {
        logic bod;
        logic ext;
        logic pwr;
    } cause_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned clk_tail(input dly_code_e code);
        return (code == DLY_LONGEST) ? LONG_CLKS : SHORT_CLKS;
    endfunction

endpackage

// File: rtl/rstseq_bod_filter.sv
module rstseq_bod_filter
    import rstseq_pkg::*;
#(
    parameter int unsigned FILT_HI_TICKS = 3,
    parameter int unsigned FILT_LO_TICKS = 7
) (
    input  logic clk,
    input  logic por_i,
    input  logic en_i,
    input  logic low_i,
    input  logic level_i,
    input  logic tick_i,
    output logic active_o
);
    localparam int unsigned FMAX = max2(FILT_HI_TICKS, FILT_LO_TICKS);
    localparam int unsigned FW   = $clog2(FMAX + 1);

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] lim;
    logic          act_q;

    always_comb lim = level_i ? FW'(FILT_HI_TICKS) : FW'(FILT_LO_TICKS);

    // A low indication must outlast the minimum: accept on tick number lim+1
    always_ff @(posedge clk) begin
        if (por_i || !en_i || !low_i) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (!act_q && tick_i) begin
            if (cnt_q == lim) act_q <= 1'b1;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active_o = act_q;

    AST_ACCEPT_NEEDS_LOW: assert property (@(posedge clk) disable iff (por_i)
        $rose(act_q) |-> $past(low_i && en_i && tick_i)); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (por_i)
        !en_i |=> !act_q); // R7

endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay
    import rstseq_pkg::*;
#(
    parameter int unsigned DLY0_TICKS = 32,
    parameter int unsigned DLY1_TICKS = 4000,
    parameter int unsigned DLY2_TICKS = 64000,
    parameter int unsigned DLY3_TICKS = 64000
) (
    input  logic      clk,
    input  logic      por_i,
    input  logic      hold_i,
    input  logic      tick_i,
    input  logic [1:0] sel_i,
    output logic      busy_o
);
    localparam int unsigned TMAX = max2(max2(DLY0_TICKS, DLY1_TICKS), max2(DLY2_TICKS, DLY3_TICKS));
    localparam int unsigned CW   = $clog2(max2(TMAX, LONG_CLKS));

    dly_code_e     code;
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tick_last;
    logic [CW-1:0] clk_last;
    logic          done;

    assign code = dly_code_e'(sel_i);

    always_comb begin
        unique case (code)
            DLY_SHORTEST: tick_last = CW'(DLY0_TICKS - 1);
            DLY_SHORT:    tick_last = CW'(DLY1_TICKS - 1);
            DLY_LONG:     tick_last = CW'(DLY2_TICKS - 1);
            default:      tick_last = CW'(DLY3_TICKS - 1);
        endcase
        clk_last = CW'(clk_tail(code) - 1);
    end

    always_ff @(posedge clk) begin
        if (por_i || hold_i) begin
            phase_q <= PH_TICKS;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_TICKS: if (tick_i) begin
                    if (cnt_q == tick_last) begin
                        phase_q <= PH_CLKS;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CLKS: begin
                    if (cnt_q == clk_last) begin
                        phase_q <= PH_DONE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done   = (phase_q == PH_DONE);
    assign busy_o = !done;

    AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (por_i)
        $rose(done) |-> ($past(phase_q) == PH_CLKS)); // R2

    AST_TICK_STALL: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_TICKS && !tick_i && !hold_i) |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               por_i,
    input  logic               ext_i,
    input  logic               bod_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output cause_t             cause_o
);
    cause_t cause_q;
    cause_t clr;

    assign clr = cause_t'(clr_i);

    always_ff @(posedge clk) begin
        if (por_i) begin
            cause_q <= '{bod: 1'b0, ext: 1'b0, pwr: 1'b1};
        end else begin
            cause_q.pwr <= cause_q.pwr & ~clr.pwr;
            cause_q.ext <= ext_i | (cause_q.ext & ~clr.ext);
            cause_q.bod <= bod_i | (cause_q.bod & ~clr.bod);
        end
    end

    assign cause_o = cause_q;

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (por_i)
        ext_i |=> cause_q.ext); // R9

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned DLY0_TICKS    = 32,
    parameter int unsigned DLY1_TICKS    = 4000,
    parameter int unsigned DLY2_TICKS    = 64000,
    parameter int unsigned DLY3_TICKS    = 64000,
    parameter int unsigned FILT_HI_TICKS = 3,
    parameter int unsigned FILT_LO_TICKS = 7
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               ext_rst_i,
    input  logic               bod_low_i,
    input  logic               bod_en_i,
    input  logic               bod_level_i,
    input  logic [1:0]         dly_sel_i,
    input  logic               tick_i,
    input  logic [CAUSE_W-1:0] flag_clr_i,
    output logic               sys_rst_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic   bod_act;
    logic   busy;
    cause_t cause;

    rstseq_bod_filter #(
        .FILT_HI_TICKS (FILT_HI_TICKS),
        .FILT_LO_TICKS (FILT_LO_TICKS)
    ) filt_i (
        .clk      (clk),
        .por_i    (por_i),
        .en_i     (bod_en_i),
        .low_i    (bod_low_i),
        .level_i  (bod_level_i),
        .tick_i   (tick_i),
        .active_o (bod_act)
    );

    rstseq_delay #(
        .DLY0_TICKS (DLY0_TICKS),
        .DLY1_TICKS (DLY1_TICKS),
        .DLY2_TICKS (DLY2_TICKS),
        .DLY3_TICKS (DLY3_TICKS)
    ) dly_i (
        .clk    (clk),
        .por_i  (por_i),
        .hold_i (ext_rst_i | bod_act),
        .tick_i (tick_i),
        .sel_i  (dly_sel_i),
        .busy_o (busy)
    );

    rstseq_cause cause_i (
        .clk     (clk),
        .por_i   (por_i),
        .ext_i   (ext_rst_i),
        .bod_i   (bod_act),
        .clr_i   (flag_clr_i),
        .cause_o (cause)
    );

    // Sources assert at once; release only through the registered delay phase
    assign sys_rst_o = por_i | ext_rst_i | bod_act | busy;
    assign cause_o   = cause;

    AST_NO_RELEASE_UNDER_EXT: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> $past(!ext_rst_i)); // R4

endmodule

// File: tb/rstseq_ctrl_tb_top.sv
module rstseq_ctrl_tb_top;
    localparam int T0 = 5, T1 = 9, T2 = 14, T3 = 20;

    logic       clk = 1'b0;
    logic       por_i = 1'b1, ext_rst_i = 1'b0, bod_low_i = 1'b0;
    logic       bod_en_i = 1'b0, bod_level_i = 1'b1, tick_i = 1'b1;
    logic [1:0] dly_sel_i = 2'b00;
    logic [2:0] flag_clr_i = 3'b000;
    logic       sys_rst_o;
    logic [2:0] cause_o;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rstseq_ctrl #(
        .DLY0_TICKS(T0), .DLY1_TICKS(T1), .DLY2_TICKS(T2), .DLY3_TICKS(T3),
        .FILT_HI_TICKS(3), .FILT_LO_TICKS(7)
    ) dut_i (
        .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .bod_low_i(bod_low_i),
        .bod_en_i(bod_en_i), .bod_level_i(bod_level_i), .dly_sel_i(dly_sel_i),
        .tick_i(tick_i), .flag_clr_i(flag_clr_i), .sys_rst_o(sys_rst_o), .cause_o(cause_o)
    );

    function automatic int tlim(input logic [1:0] s);
        case (s)
            2'b00: return T0;
            2'b01: return T1;
            2'b10: return T2;
            default: return T3;
        endcase
    endfunction

    function automatic int clen(input logic [1:0] s);
        return (s == 2'b11) ? 1024 : 18;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Inputs already released at a negedge; reset must fall after exactly 'edges' edges
    task automatic expect_release(input string req, input int edges);
        if (edges > 1) begin
            step(edges - 1);
            check(req, "reset still held one edge before release", sys_rst_o, 1);
        end
        step(1);
        check(req, "reset released", sys_rst_o, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic t_power_on();
        step(3);
        check("R3", "reset during power-on", sys_rst_o, 1);
        check("R3", "cause after power-on", cause_o, 3'b001);
        por_i = 1'b0;
        expect_release("R3", T0 + 18);
    endtask

    task automatic t_ext_delay(input logic [1:0] s);
        dly_sel_i = s;
        ext_rst_i = 1'b1;
        #1 check("R4", "combinational assert from external request", sys_rst_o, 1);
        step(2);
        check("R9", "external cause flag", cause_o[1], 1);
        ext_rst_i = 1'b0;
        expect_release(s == 2'b11 ? "R2" : "R1", tlim(s) + clen(s));
    endtask

    task automatic t_tick_only();
        dly_sel_i = 2'b00;
        tick_i = 1'b0;
        ext_rst_i = 1'b1;
        step(1);
        ext_rst_i = 1'b0;
        step(40);
        check("R1", "no progress without ticks", sys_rst_o, 1);
        tick_i = 1'b1;
        expect_release("R1", T0 + 18);
    endtask

    task automatic t_restart();
        dly_sel_i = 2'b00;
        ext_rst_i = 1'b1;
        step(1);
        ext_rst_i = 1'b0;
        step(T0 + 10);
        check("R4", "in clock stage", sys_rst_o, 1);
        ext_rst_i = 1'b1;
        step(1);
        ext_rst_i = 1'b0;
        expect_release("R4", T0 + 18);
    endtask

    task automatic clear_flags();
        flag_clr_i = 3'b111;
        step(1);
        flag_clr_i = 3'b000;
    endtask

    task automatic t_filter(input logic lvl);
        int lim = lvl ? 3 : 7;
        dly_sel_i = 2'b00;
        bod_en_i = 1'b1;
        bod_level_i = lvl;
        clear_flags();
        bod_low_i = 1'b1;
        step(lim);
        bod_low_i = 1'b0;
        step(1);
        check("R6", "short low indication ignored", sys_rst_o, 0);
        step(1);
        check("R6", "short low leaves no cause", cause_o[2], 0);
        bod_low_i = 1'b1;
        step(lim + 1);
        check("R5", "brown-out asserts after accepting edge", sys_rst_o, 1);
        step(5);
        check("R9", "brown-out cause flag", cause_o[2], 1);
        bod_low_i = 1'b0;
        expect_release("R8", T0 + 18 + 1);
    endtask

    task automatic t_disable();
        dly_sel_i = 2'b00;
        bod_level_i = 1'b1;
        clear_flags();
        bod_en_i = 1'b0;
        bod_low_i = 1'b1;
        step(30);
        check("R7", "disabled detector has no effect", sys_rst_o, 0);
        check("R7", "disabled detector sets no cause", cause_o[2], 0);
        bod_en_i = 1'b1;
        step(4);
        check("R7", "enabled detector accepts", sys_rst_o, 1);
        bod_en_i = 1'b0;
        expect_release("R7", T0 + 18 + 1);
        bod_low_i = 1'b0;
    endtask

    task automatic t_clear();
        clear_flags();
        check("R9", "flags cleared by write-one", cause_o, 3'b000);
        ext_rst_i = 1'b1;
        flag_clr_i = 3'b010;
        step(1);
        flag_clr_i = 3'b000;
        ext_rst_i = 1'b0;
        check("R9", "set wins over clear", cause_o[1], 1);
        expect_release("R9", T0 + 18);
    endtask

    task automatic t_por_again();
        ext_rst_i = 1'b1;
        step(2);
        ext_rst_i = 1'b0;
        por_i = 1'b1;
        step(2);
        check("R3", "power-on rewrites cause flags", cause_o, 3'b001);
        por_i = 1'b0;
        expect_release("R3", T0 + 18);
    endtask

    initial begin
        @(negedge clk);
        t_power_on();
        for (int s = 0; s < 4; s++) t_ext_delay(2'(s));
        t_tick_only();
        t_restart();
        t_filter(1'b1);
        t_filter(1'b0);
        t_disable();
        t_clear();
        t_por_again();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule